// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block paces periodic all-bank refresh for a single DRAM rank. A free-running interval timer marks a refresh as due once per refresh interval. When a refresh is due, the sequencer stops the scheduler from starting new accesses. It then lets the accesses already in flight run to completion while the open rows stay open. Next it asks for every open bank to be precharged and waits the precharge recovery time. Finally it strobes one refresh command and reports the rank busy for the refresh cycle time before it returns to idle.

The surrounding controller supplies three inputs: a level that says accesses are still in flight, the number of banks that currently hold an open row, and a one-cycle handshake that confirms the precharge-all has been issued. The due times sit on a fixed grid anchored at reset. A long drain therefore delays one refresh but does not shift any later one.

Top module: `refresh_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `seq_state_o` is 0 and `hold_new_o`, `pre_all_req_o`, `ref_cmd_o` and `rank_busy_o` are all low.
- R2: `seq_state_o` reports the phase as IDLE=0, DRAIN=1, PRE=2, RUN=3. The machine enters DRAIN on the clock edge numbered k*T_REFI after reset release (k = 1, 2, ...), provided it is idle at that point.
- R3: `hold_new_o` is high exactly when the phase is not IDLE.
- R4: While `in_flight_i` is high in DRAIN, the machine stays in DRAIN and issues neither a precharge request nor a refresh command. The edge that samples `in_flight_i` low moves it to PRE.
- R5: If `open_banks_i` is nonzero on leaving DRAIN, `pre_all_req_o` rises with the entry into PRE and stays high until the edge that samples `pre_done_i` high.
- R6: After the edge that accepts `pre_done_i`, RUN is entered T_RP+1 edges later, so at least T_RP cycles separate the precharge from the refresh.
- R7: If `open_banks_i` is zero on leaving DRAIN, PRE lasts exactly one cycle and `pre_all_req_o` never rises.
- R8: `ref_cmd_o` is a one-cycle pulse in the first RUN cycle. `rank_busy_o` is high for exactly T_RFC cycles, after which the phase returns to IDLE.
- R9: Due times do not drift. The DRAIN entries stay on the k*T_REFI grid whatever the length of the previous drain or precharge wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flight_i | input | 1 | High while accesses to the rank are outstanding |
| open_banks_i | input | $clog2(BANKS+1) | Number of banks with an open row |
| pre_done_i | input | 1 | One-cycle confirmation that precharge-all was issued |
| hold_new_o | output | 1 | Block new requests to the rank |
| pre_all_req_o | output | 1 | Request precharge of all banks |
| ref_cmd_o | output | 1 | One-cycle refresh command strobe |
| rank_busy_o | output | 1 | Rank occupied by refresh |
| seq_state_o | output | 2 | Current phase (IDLE=0, DRAIN=1, PRE=2, RUN=3) |

## Verification
The assertions assume two things about the inputs. First, `pre_done_i` is only pulsed while a precharge request is pending. Second, the whole refresh sequence finishes well inside one refresh interval, so no due event arrives outside IDLE. The stimulus keeps to both. It raises `in_flight_i` and sets the open-bank count only while idle. It drops `in_flight_i` during DRAIN and pulses the handshake only after it observes the request. It picks drain lengths and handshake delays that together stay far below T_REFI. Scenarios alternate between open and closed banks and between zero and long drains, so that the grid of refresh start times is checked after varied sequence lengths.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_PRE   = 2'd2,
        RS_RUN   = 2'd3
    } ref_phase_e;

    typedef struct packed {
        ref_phase_e phase;
        logic       pend;
        logic       pre_req;
        logic       cmd;
    } seq_regs_t;

endpackage

// File: rtl/ref_due_timer.sv
module ref_due_timer #(
    parameter int PERIOD = 7800
) (
    input  logic clk,
    input  logic rst_n,
    output logic due_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Fixed grid: reload on expiry, never on refresh completion.
    always_comb begin
        due_o = (cnt_q == '0);
        cnt_d = due_o ? RELOAD : cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ref_wait_timer.sv
module ref_wait_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = (cnt_q == '0);
        if (load_i)          cnt_d = load_val_i;
        else if (!expired_o) cnt_d = cnt_q - 1'b1;
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import refresh_seq_pkg::*;
#(
    parameter int T_REFI = 7800,
    parameter int T_RFC  = 260,
    parameter int T_RP   = 14,
    parameter int BANKS  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_flight_i,
    input  logic [$clog2(BANKS+1)-1:0]   open_banks_i,
    input  logic                         pre_done_i,
    output logic                         hold_new_o,
    output logic                         pre_all_req_o,
    output logic                         ref_cmd_o,
    output logic                         rank_busy_o,
    output logic [1:0]                   seq_state_o
);
    localparam int MAXW   = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int WAIT_W = $clog2(MAXW + 1);
    localparam logic [WAIT_W-1:0] RP_VAL  = WAIT_W'(T_RP);
    localparam logic [WAIT_W-1:0] RFC_VAL = WAIT_W'(T_RFC - 1);

    seq_regs_t         s_d, s_q;
    logic              due;
    logic              expired;
    logic              tmr_load;
    logic [WAIT_W-1:0] tmr_val;

    ref_due_timer #(.PERIOD(T_REFI)) due_i (
        .clk   (clk),
        .rst_n (rst_n),
        .due_o (due)
    );

    ref_wait_timer #(.W(WAIT_W)) wait_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (expired)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = 1'b0;
        s_d.pend = s_q.pend | due;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.phase)
            RS_IDLE: begin
                if (s_d.pend) begin
                    s_d.phase = RS_DRAIN;
                    s_d.pend  = 1'b0;
                end
            end
            RS_DRAIN: begin
                if (!in_flight_i) begin
                    s_d.phase   = RS_PRE;
                    s_d.pre_req = (open_banks_i != '0);
                end
            end
            RS_PRE: begin
                if (s_q.pre_req) begin
                    if (pre_done_i) begin
                        s_d.pre_req = 1'b0;
                        tmr_load    = 1'b1;
                        tmr_val     = RP_VAL;
                    end
                end else if (expired) begin
                    s_d.phase = RS_RUN;
                    s_d.cmd   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = RFC_VAL;
                end
            end
            RS_RUN: begin
                if (expired) s_d.phase = RS_IDLE;
            end
            default: s_d.phase = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: RS_IDLE, pend: 1'b0, pre_req: 1'b0, cmd: 1'b0};
        else        s_q <= s_d;
    end

    assign hold_new_o    = (s_q.phase != RS_IDLE);
    assign pre_all_req_o = s_q.pre_req;
    assign ref_cmd_o     = s_q.cmd;
    assign rank_busy_o   = (s_q.phase == RS_RUN);
    assign seq_state_o   = s_q.phase;

    a_r4_stay_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 2'd1 && in_flight_i) |=> (seq_state_o == 2'd1 && !pre_all_req_o));

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_req_o && !pre_done_i) |=> pre_all_req_o);

    a_r6_trp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_req_o && pre_done_i) |=> (!rank_busy_o && !ref_cmd_o));

    a_r7_skip_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 2'd1 && !in_flight_i && open_banks_i == '0)
        |=> (seq_state_o == 2'd2 && !pre_all_req_o));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd_o |=> !ref_cmd_o);

    a_r8_cmd_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rank_busy_o) |-> ref_cmd_o);

    a_r3_hold_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_req_o || rank_busy_o) |-> hold_new_o);
endmodule

// File: tb/refresh_seq_tb_top.sv
module refresh_seq_tb_top;
    localparam int T_REFI = 200;
    localparam int T_RFC  = 12;
    localparam int T_RP   = 3;
    localparam int BANKS  = 8;
    localparam int BW     = $clog2(BANKS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_flight = 1'b0;
    logic [BW-1:0] open_banks = '0;
    logic          pre_done = 1'b0;
    logic          hold_new, pre_req, ref_cmd, busy;
    logic [1:0]    st;

    int cyc = 0;
    int vectors = 0;
    int fails = 0;

    typedef struct {
        int    kind;
        int    at;
        int    st;
        string req;
    } ev_t;
    ev_t exp_q[$];

    always #4 clk = ~clk;

    refresh_seq #(.T_REFI(T_REFI), .T_RFC(T_RFC), .T_RP(T_RP), .BANKS(BANKS)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_flight_i   (in_flight),
        .open_banks_i  (open_banks),
        .pre_done_i    (pre_done),
        .hold_new_o    (hold_new),
        .pre_all_req_o (pre_req),
        .ref_cmd_o     (ref_cmd),
        .rank_busy_o   (busy),
        .seq_state_o   (st)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    // Monitor: turn output edges into events and compare with the queue head.
    logic prev_hold = 1'b0, prev_pre = 1'b0;
    int   busy_len = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy) busy_len++;
                for (int k = 0; k < 4; k++) begin
                    bit hit;
                    hit = (k == 0) ? (hold_new && !prev_hold) :
                          (k == 1) ? (pre_req && !prev_pre) :
                          (k == 2) ? ref_cmd : (!hold_new && prev_hold);
                    if (hit) begin
                        if (exp_q.size() == 0) begin
                            check("unexpected event R4/R7/R8", k, -1);
                        end else begin
                            ev_t e;
                            e = exp_q.pop_front();
                            check({e.req, " kind"}, k, e.kind);
                            check({e.req, " cycle"}, cyc, e.at);
                            check({e.req, " phase R2"}, int'(st), e.st);
                            if (k == 3) begin
                                check("R8 busy length", busy_len, T_RFC);
                                busy_len = 0;
                            end
                            if (k == 2) check("R8 busy with cmd", int'(busy), 1);
                        end
                    end
                end
                prev_hold = hold_new;
                prev_pre  = pre_req;
            end
        end
    end

    // Driver: one refresh round; pushes the events the requirements predict.
    task automatic round(input int k, input int nb, input int d, input int p);
        int s, r;
        s = k * T_REFI;
        r = (nb != 0) ? s + d + p + T_RP + 3 : s + d + 2;
        wait_cyc(s - 5);
        in_flight  = (d > 0);
        open_banks = BW'(nb);
        exp_q.push_back('{0, s, 1, "R2/R9 drain entry"});
        if (nb != 0) exp_q.push_back('{1, s + d + 1, 2, "R5 precharge request"});
        exp_q.push_back('{2, r, 3, (nb != 0) ? "R6 refresh after tRP" : "R7 skip precharge"});
        exp_q.push_back('{3, r + T_RFC, 0, "R8/R3 release"});
        if (d > 0) begin
            wait_cyc(s + d);
            in_flight = 1'b0;
        end
        if (nb != 0) begin
            wait_cyc(s + d + 1 + p);
            check("R5 request still held", int'(pre_req), 1);
            pre_done = 1'b1;
            @(negedge clk);
            pre_done = 1'b0;
        end
        wait_cyc(r + T_RFC + 2);
        check("R3 hold low in idle", int'(hold_new), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(st), 0);
        check("R1 reset outputs", int'({hold_new, pre_req, ref_cmd, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle", int'({st, hold_new, pre_req, ref_cmd, busy}), 0);
        round(1, 3, 10, 4);
        round(2, 0, 0, 0);
        round(3, 1, 40, 7);
        round(4, 0, 5, 0);
        round(5, 7, 0, 0);
        round(6, 8, 60, 20);
        check("R9 all events seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule